// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is an 8-bit serial transceiver that shifts on a clock. It sits on a 4-bit peripheral register bus. Software writes the outgoing byte as two nibbles, enables the unit and sets a start bit. The unit then clocks eight bits out on `sout` while taking eight bits in from `sin`. The received byte replaces the transmit byte in the same register pair. The start bit reads back as a busy flag until the eighth shift clock completes.

The shift clock has two possible sources. In internal mode the unit makes its own clock on `sclk_out`: each half period lasts `DIV` system clocks, and the line idles high. In external mode the unit follows edges on `sclk_in`, after passing them through a two-stage synchroniser. When a transfer ends, a sticky completion flag is set. That flag, gated by a mask bit, drives `irq`.

The byte is exchanged through registers, so the block has no streaming port and no valid/ready handshake. All pins are plain control, status or serial lines. Software takes care of back-pressure: it must not start a new transfer while the busy flag reads 1.

Register map on `bus_addr`:
- Address 0 is the control register. Bit 0 is the enable. Bit 1 is the start bit when written and the busy flag when read. Bit 2 selects the external clock. Bit 3 is the completion flag, and writing 1 to it clears it.
- Address 1, bit 0, is the interrupt mask.
- Address 2 holds data bits 3:0.
- Address 3 holds data bits 7:4.

Top module: `sif_xcvr`

## Requirements
- R1: After reset, address 0 reads 0 and address 1 reads 0. `irq` is low, and both `sout` and `sclk_out` are high.
- R2: Writing 1 to control bit 1 is ignored unless a read or write of address 2 or 3 has occurred since the last accepted start. Such an access counts only if it happens while the unit is stopped.
- R3: Writing 1 to control bit 1 is ignored unless the enable (control bit 0) was already 1 before that write.
- R4: Control bit 1 reads 1 from the cycle after an accepted start. In internal mode it reads 0 again exactly 16*DIV system clocks after the edge that accepted the start.
- R5: `sout` sends data bit 0 first. It changes only on a falling shift-clock edge and is stable at each rising edge.
- R6: `sin` is sampled on each rising shift-clock edge. The first sampled bit ends up in data bit 0, and the received byte can be read at addresses 2 and 3.
- R7: A start written while the unit is busy is ignored, and the running transfer still takes exactly eight shift clocks.
- R8: When control bit 2 is 1, shifting follows only `sclk_in` edges that arrive after the start. Edges seen before the start have no effect.
- R9: Completion sets control bit 3. Writing 1 to bit 3 clears it. `irq` equals the flag ANDed with the mask bit (address 1, bit 0).
- R10: If the flag is set by a completion and cleared by a write in the same cycle, the set wins.
- R11: In internal mode `sclk_out` stays high while stopped. A transfer produces exactly eight low pulses, and each half period lasts DIV system clocks.
- R12: Writes to addresses 2 and 3 while busy are ignored and do not disturb the bits being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (arms the unit on data addresses) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble, decoded from `bus_addr` |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock, idle high |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| irq | output | 1 | Masked completion interrupt |

## Verification
Two functions can meet in one cycle: the completion flag being set by the last rising shift edge, and software clearing that flag with a write of 1.

The bench first finishes one transfer and leaves its flag set. It then starts an internal-clock transfer and counts system clocks so that the clearing write is sampled on exactly the edge that ends the transfer.

During that write it checks that the busy flag still reads 1. On the next cycle it expects the busy flag at 0 and the completion flag still at 1. This confirms both the R4 timing and that the set wins over the clear.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_MASK = 2'd1,
    A_DLO  = 2'd2,
    A_DHI  = 2'd3
  } sif_addr_e;

  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_RUN  = 1;
  localparam int unsigned C_EXT  = 2;
  localparam int unsigned C_FLAG = 3;
endpackage

// File: rtl/sif_regs.sv
module sif_regs
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [NIB_W-1:0]  rdata_o,
  input  logic              run_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              start_o,
  output logic              ext_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              irq_o
);
  logic enable_q, ext_q, flag_q, mask_q, armed_q;
  logic ctrl_wr, data_acc;

  assign ctrl_wr  = we_i && (addr_i == A_CTRL);
  assign data_acc = (we_i || re_i) && (addr_i == A_DLO || addr_i == A_DHI);
  assign start_o  = ctrl_wr && wdata_i[C_RUN] && enable_q && armed_q && !run_i;
  assign wr_lo_o  = we_i && (addr_i == A_DLO) && !run_i;
  assign wr_hi_o  = we_i && (addr_i == A_DHI) && !run_i;
  assign ext_o    = ext_q;
  assign irq_o    = flag_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      ext_q    <= 1'b0;
      flag_q   <= 1'b0;
      mask_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        enable_q <= wdata_i[C_EN];
        ext_q    <= wdata_i[C_EXT];
      end
      if (we_i && addr_i == A_MASK) mask_q <= wdata_i[0];
      if (done_i) flag_q <= 1'b1;
      else if (ctrl_wr && wdata_i[C_FLAG]) flag_q <= 1'b0;
      if (start_o) armed_q <= 1'b0;
      else if (data_acc && !run_i) armed_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (sif_addr_e'(addr_i))
      A_CTRL:  rdata_o = {flag_q, ext_q, run_i, enable_q};
      A_MASK:  rdata_o = {3'b000, mask_q};
      A_DLO:   rdata_o = data_i[NIB_W-1:0];
      default: rdata_o = data_i[BYTE_W-1:NIB_W];
    endcase
  end

  p_start_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> $past(armed_q));
  p_start_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> $past(enable_q));
  p_flag_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> flag_q);
endmodule

// File: rtl/sif_clkgen.sv
module sif_clkgen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic ext_i,
  input  logic sclk_in,
  output logic sclk_out,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic sclk_q, mode_q;
  logic [2:0] sync_q;
  logic tick, int_fall, int_rise, ext_fall, ext_rise;

  assign tick     = run_i && !mode_q && (cnt_q == CMAX);
  assign int_fall = tick && sclk_q;
  assign int_rise = tick && !sclk_q;
  assign ext_fall = run_i && mode_q && sync_q[2] && !sync_q[1];
  assign ext_rise = run_i && mode_q && !sync_q[2] && sync_q[1];
  assign fall_o   = int_fall | ext_fall;
  assign rise_o   = int_rise | ext_rise;
  assign sclk_out = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
      mode_q <= 1'b0;
      sync_q <= 3'b111;
    end else begin
      sync_q <= {sync_q[1:0], sclk_in};
      if (start_i) begin
        mode_q <= ext_i;
        cnt_q  <= '0;
        sclk_q <= 1'b1;
      end else if (run_i && !mode_q) begin
        if (tick) begin
          cnt_q  <= '0;
          sclk_q <= ~sclk_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> sclk_q);
  p_edge_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_o && rise_o));
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sin,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [NIB_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              sout,
  output logic              run_o,
  output logic              done_o
);
  localparam int unsigned BCW = $clog2(BYTE_W);
  localparam logic [BCW-1:0] LAST = BCW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BCW-1:0] cnt_q;
  logic run_q, sout_q;

  assign done_o = run_q && rise_i && (cnt_q == LAST);
  assign data_o = sh_q;
  assign sout   = sout_q;
  assign run_o  = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      sout_q <= 1'b1;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (fall_i) sout_q <= sh_q[0];
      if (rise_i) begin
        sh_q  <= {sin, sh_q[BYTE_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) run_q <= 1'b0;
      end
    end else begin
      if (wr_lo_i) sh_q[NIB_W-1:0] <= wdata_i;
      if (wr_hi_i) sh_q[BYTE_W-1:NIB_W] <= wdata_i;
    end
  end

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !run_q);
  p_stop_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !run_q);
endmodule

// File: rtl/sif_xcvr.sv
module sif_xcvr
  import sif_pkg::*;
#(
  parameter int unsigned DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sin,
  output logic              sout,
  output logic              irq
);
  logic start, ext, wr_lo, wr_hi, run, done, fall, rise;
  logic [BYTE_W-1:0] data;

  sif_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .re_i(bus_re), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .run_i(run), .done_i(done),
    .data_i(data), .start_o(start), .ext_o(ext), .wr_lo_o(wr_lo),
    .wr_hi_o(wr_hi), .irq_o(irq)
  );

  sif_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run), .ext_i(ext),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .fall_o(fall), .rise_o(rise)
  );

  sif_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fall_i(fall), .rise_i(rise),
    .sin(sin), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(bus_wdata),
    .data_o(data), .sout(sout), .run_o(run), .done_o(done)
  );

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> bus_addr != A_CTRL || bus_rdata[C_FLAG]);
endmodule

// File: tb/tb_sif_xcvr.sv
module tb_sif_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [1:0] bus_addr = 0;
  logic [3:0] bus_wdata = 0;
  logic [3:0] bus_rdata;
  logic sclk_in = 1, sclk_out, sin = 0, sout, irq;

  int checks = 0, errors = 0;
  bit ext_mode = 0, mon_en = 0;
  bit exp_q[$];
  logic [7:0] rx_pat;
  int sin_idx = 0, rises = 0;
  logic [3:0] rd;

  sif_xcvr #(.DIV(DIV)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  wire mon_clk = ext_mode ? sclk_in : sclk_out;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected serial bit on each rising shift edge
  always @(posedge mon_clk) if (mon_en) begin
    rises++;
    if (exp_q.size() == 0) chk("R5 unexpected edge", 1, 0);
    else chk("R5 sout bit", sout, exp_q.pop_front());
  end
  always @(negedge mon_clk) if (mon_en) begin
    if (sin_idx < 8) sin = rx_pat[sin_idx];
    sin_idx++;
  end

  task automatic bus_write(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [3:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  // Driver: pushes the expected serial bits (LSB first), arms and loads
  task automatic load(input logic [7:0] tx, input logic [7:0] rx);
    for (int i = 0; i < 8; i++) exp_q.push_back(tx[i]);
    rx_pat = rx; sin_idx = 0; rises = 0;
    bus_write(2, tx[3:0]);
    bus_write(3, tx[7:4]);
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 400; i++) begin
      bus_read(0, rd);
      if (!rd[1]) break;
    end
  endtask

  task automatic check_rx(input logic [7:0] rx, input string req);
    logic [3:0] lo, hi;
    mon_en = 0;
    bus_read(2, lo); bus_read(3, hi);
    chk(req, {hi, lo}, rx);
    chk("R11 eight rising shift edges", rises, 8);
    chk("R5 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_read(0, rd); chk("R1 ctrl", rd, 0);
    bus_read(1, rd); chk("R1 mask", rd, 0);
    chk("R1 irq", irq, 0); chk("R1 sout", sout, 1); chk("R1 sclk_out", sclk_out, 1);

    // R2 start with no prior data access
    bus_write(0, 4'b0001);
    bus_write(0, 4'b0011);
    bus_read(0, rd); chk("R2 unarmed start ignored", rd[1], 0);

    // R3 start with enable clear
    bus_write(0, 4'b0000);
    bus_write(2, 4'h1);
    bus_write(0, 4'b0010);
    bus_read(0, rd); chk("R3 disabled start ignored", rd[1], 0);
    bus_write(0, 4'b0001);

    // Internal transfer with mid-run retrigger and data write (R7, R12)
    ext_mode = 0; mon_en = 1;
    load(8'hA5, 8'h3C);
    bus_write(0, 4'b0011);
    bus_read(0, rd); chk("R4 busy after start", rd[1], 1);
    bus_write(2, 4'hF);       // R12 ignored while busy
    bus_write(0, 4'b0011);    // R7 ignored while busy
    wait_stop();
    check_rx(8'h3C, "R6 received byte");
    bus_read(0, rd); chk("R9 flag set", rd[3], 1);
    chk("R9 irq masked", irq, 0);
    bus_write(1, 4'h1);
    bus_read(1, rd); chk("R9 mask readback", rd, 1);
    #1 chk("R9 irq unmasked", irq, 1);
    bus_write(0, 4'b1001);
    bus_read(0, rd); chk("R9 flag cleared", rd[3], 0);
    chk("R9 irq after clear", irq, 0);

    // External transfer with edges before the start (R8)
    bus_write(0, 4'b0101);
    ext_mode = 1;
    load(8'h3C, 8'h96);
    for (int i = 0; i < 3; i++) begin
      repeat (4) @(negedge clk); sclk_in = 0;
      repeat (4) @(negedge clk); sclk_in = 1;
    end
    repeat (4) @(negedge clk);
    bus_write(0, 4'b0111);
    mon_en = 1;
    for (int i = 0; i < 8; i++) begin
      repeat (4) @(negedge clk); sclk_in = 0;
      repeat (4) @(negedge clk); sclk_in = 1;
      if (i == 6) begin
        repeat (5) @(negedge clk);
        bus_read(0, rd); chk("R8 busy after seven edges", rd[1], 1);
      end
    end
    repeat (5) @(negedge clk);
    bus_read(0, rd); chk("R8 stopped after eighth edge", rd[1], 0);
    check_rx(8'h96, "R8 external received byte");
    bus_read(0, rd); chk("R9 flag after ext", rd[3], 1);

    // R10 and R4 exact timing: clear lands on the completion edge
    bus_write(0, 4'b0001);
    ext_mode = 0;
    load(8'h5A, 8'hC3);
    mon_en = 1;
    bus_write(0, 4'b0011);
    repeat (16*DIV - 2) @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 4'b1001;
    #1 chk("R4 busy on last cycle", bus_rdata[1], 1);
    @(negedge clk); bus_we = 0;
    #1 chk("R4 stopped exactly at 16*DIV", bus_rdata[1], 0);
    chk("R10 set wins over clear", bus_rdata[3], 1);
    chk("R10 irq held", irq, 1);
    check_rx(8'hC3, "R6 received byte 2");
    bus_write(0, 4'b1001);
    bus_read(0, rd); chk("R9 final clear", rd[3], 0);
    chk("R11 idle high", sclk_out, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule